// File: doc/BRIEF.md
# Debug Register Write Gate with Lock and Ownership Tag

This block guards write access to the control registers of a debug component. It sits between a simple register bus (address, write enable, write data, read data) and the component's functional register file. The block holds a key-protected lock, a read-only lock status word and a small ownership tag. The tag is changed through two addresses: one sets bits and one clears them.

For each bus write, the block raises `wrPermit` when the functional register file may accept the write. While the lock is engaged, every write is refused except a write to the lock access address. A refused write still completes on the bus but has no effect. The block returns read data only for its own status and tag addresses. For every other address it returns zero, so the surrounding logic can OR the result with the register file's read data.

Top module: `dbg_write_gate`

## Requirements
- R1: Out of reset the lock is engaged, all ownership bits are 0, and a read of offset 0xFB4 returns 0x3.
- R2: A read of offset 0xFB4 returns bit 0 = 1 (a lock is implemented), bit 1 = the current lock state (1 = locked), and bit 2 = 0 (32-bit access register). All other bits read 0.
- R3: A write of 0xC5ACCE55 to offset 0xFB0 clears the lock from the next cycle on. A write of any other value to 0xFB0 engages the lock. This works whether the lock is engaged or not.
- R4: Offset 0xFB0 is write-only and reads as 0.
- R5: While the lock is engaged, `wrPermit` stays 0 and writes to 0xFA0 and 0xFA4 leave the ownership bits unchanged.
- R6: While unlocked, `wrPermit` equals `busWrEn` for any address other than 0xFA0, 0xFA4, 0xFB0 and 0xFB4. It is always 0 for those four addresses and whenever `busWrEn` is 0.
- R7: A read of offset 0xFA0 returns a mask of the implemented ownership bits: 0xF with the default of four bits.
- R8: An unlocked write to 0xFA0 sets each ownership bit whose data bit is 1 and leaves the others unchanged. Data bits above the implemented ones are ignored.
- R9: An unlocked write to 0xFA4 clears each ownership bit whose data bit is 1. A read of 0xFA4 returns the current ownership bits.
- R10: Writes to 0xFB4 have no effect on the lock state.
- R11: Reads of any address not owned by the block return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W (12) | Register byte offset of the current access |
| busWrEn | input | 1 | Write strobe for the current access |
| busWrData | input | DATA_W (32) | Write data |
| rdData | output | DATA_W (32) | Read data for the block's own addresses, 0 elsewhere |
| wrPermit | output | 1 | Write may update the functional register file |

## Verification
The bench first writes near-miss keys, one bit away from the real key. A design that compares only part of the key would unlock on one of them. It then writes to the ownership addresses while the lock is engaged, which catches a gate that lets those writes through or lets `wrPermit` rise. Set and clear writes carry data in the upper, unimplemented bits. A design without the mask would report extra ownership bits or a wrong mask. Random sequences mix lock, unlock, status writes and reads at foreign addresses, to catch a lock that changes on a status write or stray read data.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;

  localparam logic [11:0] OFS_LOCK_ACCESS = 12'hFB0;
  localparam logic [11:0] OFS_LOCK_STATUS = 12'hFB4;
  localparam logic [11:0] OFS_CLAIM_SET   = 12'hFA0;
  localparam logic [11:0] OFS_CLAIM_CLR   = 12'hFA4;
  localparam logic [31:0] UNLOCK_KEY      = 32'hC5AC_CE55;

  typedef struct packed {
    logic locked;
    logic claimSetWr;
    logic claimClrWr;
    logic selLockStat;
    logic selClaimSet;
    logic selClaimClr;
  } gateStrobes_t;

endpackage

// File: rtl/dbg_gate_ctrl.sv
module dbg_gate_ctrl
  import dbg_gate_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output gateStrobes_t      strobes,
  output logic              wrPermit
);

  localparam logic [DATA_W-1:0] KEY_W = DATA_W'(UNLOCK_KEY);

  logic hitLockAcc, hitLockStat, hitClaimSet, hitClaimClr, ownAddr;
  logic lockWr, writeOk, locked;

  assign hitLockAcc  = (busAddr == ADDR_W'(OFS_LOCK_ACCESS));
  assign hitLockStat = (busAddr == ADDR_W'(OFS_LOCK_STATUS));
  assign hitClaimSet = (busAddr == ADDR_W'(OFS_CLAIM_SET));
  assign hitClaimClr = (busAddr == ADDR_W'(OFS_CLAIM_CLR));
  assign ownAddr     = hitLockAcc | hitLockStat | hitClaimSet | hitClaimClr;

  // The lock access register is the only write the lock never blocks.
  assign lockWr  = busWrEn & hitLockAcc;
  assign writeOk = busWrEn & ~locked;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       locked <= 1'b1;
    else if (lockWr) locked <= (busWrData != KEY_W);
  end

  always_comb begin
    strobes.locked      = locked;
    strobes.claimSetWr  = writeOk & hitClaimSet;
    strobes.claimClrWr  = writeOk & hitClaimClr;
    strobes.selLockStat = hitLockStat;
    strobes.selClaimSet = hitClaimSet;
    strobes.selClaimClr = hitClaimClr;
  end

  assign wrPermit = writeOk & ~ownAddr;

  AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (lockWr && busWrData == KEY_W) |=> !locked); // R3
  AST_BAD_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (lockWr && busWrData != KEY_W) |=> locked); // R3
  AST_LOCKED_NO_PERMIT: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> !wrPermit); // R5
  AST_STATUS_WR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && hitLockStat) |=> $stable(locked)); // R10

endmodule

// File: rtl/dbg_gate_datapath.sv
module dbg_gate_datapath
  import dbg_gate_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CLAIM_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  gateStrobes_t          strobes,
  input  logic [CLAIM_BITS-1:0] claimWrBits,
  output logic [DATA_W-1:0]     rdData
);

  localparam logic [CLAIM_BITS-1:0] CLAIM_MASK = {CLAIM_BITS{1'b1}};

  logic [CLAIM_BITS-1:0] claimTag;

  for (genvar b = 0; b < CLAIM_BITS; b++) begin : g_claimBit
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                      claimTag[b] <= 1'b0;
      else if (strobes.claimSetWr && claimWrBits[b])  claimTag[b] <= 1'b1;
      else if (strobes.claimClrWr && claimWrBits[b])  claimTag[b] <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    if (strobes.selLockStat)      rdData[1:0] = {strobes.locked, 1'b1};
    else if (strobes.selClaimSet) rdData[CLAIM_BITS-1:0] = CLAIM_MASK;
    else if (strobes.selClaimClr) rdData[CLAIM_BITS-1:0] = claimTag;
  end

  AST_TAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.claimSetWr && !strobes.claimClrWr) |=> $stable(claimTag)); // R5
  AST_SET_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.claimSetWr |=> ((claimTag & $past(claimWrBits)) == $past(claimWrBits))); // R8
  AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.claimClrWr |=> ((claimTag & $past(claimWrBits)) == '0)); // R9
  AST_STATUS_FORM: assert property (@(posedge clk) disable iff (!rstN)
    strobes.selLockStat |-> (rdData[0] && rdData[DATA_W-1:2] == '0)); // R2

endmodule

// File: rtl/dbg_write_gate.sv
module dbg_write_gate
  import dbg_gate_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int CLAIM_BITS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] rdData,
  output logic              wrPermit
);

  gateStrobes_t strobes;
  logic [CLAIM_BITS-1:0] claimWrBits;

  assign claimWrBits = busWrData[CLAIM_BITS-1:0];

  dbg_gate_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .strobes(strobes), .wrPermit(wrPermit)
  );

  dbg_gate_datapath #(.DATA_W(DATA_W), .CLAIM_BITS(CLAIM_BITS)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .claimWrBits(claimWrBits),
    .rdData(rdData)
  );

endmodule

// File: tb/dbg_write_gate_tb_top.sv
module dbg_write_gate_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'hC5AC_CE55;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] rdData;
  logic        wrPermit;

  int checks = 0;
  int failures = 0;
  bit mLocked = 1'b1;
  logic [3:0] mClaim = 4'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_write_gate dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .rdData(rdData), .wrPermit(wrPermit)
  );

  function automatic logic [31:0] expRead(logic [11:0] a);
    case (a)
      12'hFB4: return {30'd0, mLocked, 1'b1};   // R2
      12'hFA0: return 32'hF;                    // R7
      12'hFA4: return {28'd0, mClaim};          // R9
      default: return 32'h0;                    // R4, R11
    endcase
  endfunction

  function automatic bit expPermit(logic [11:0] a, bit we);
    bit own = (a == 12'hFB0) || (a == 12'hFB4) || (a == 12'hFA0) || (a == 12'hFA4);
    return we && !mLocked && !own;              // R5, R6
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [11:0] a, logic [31:0] d, string req);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b1; busWrData = d;
    #1;
    check({req, " permit"}, {31'd0, wrPermit}, {31'd0, expPermit(a, 1'b1)});
    @(posedge clk);
    if (a == 12'hFB0) mLocked = (d != KEY);
    else if (!mLocked && a == 12'hFA0) mClaim = mClaim | d[3:0];
    else if (!mLocked && a == 12'hFA4) mClaim = mClaim & ~d[3:0];
  endtask

  task automatic doRead(logic [11:0] a, string req);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b0; busWrData = $urandom;
    #1;
    check(req, rdData, expRead(a));
    check("R6 no permit without write", {31'd0, wrPermit}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240613));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // Reset state
    doRead(12'hFB4, "R1 status after reset");
    doRead(12'hFA4, "R1 tag after reset");
    doRead(12'hFB0, "R4 access reg reads zero");
    doRead(12'hFA0, "R7 mask");
    doRead(12'h123, "R11 foreign read");

    // Locked: writes blocked
    doWrite(12'hFA0, 32'hF, "R5 set while locked");
    doRead(12'hFA4, "R5 tag unchanged");
    doWrite(12'h010, 32'h1, "R5 foreign while locked");

    // Near-miss keys
    for (int b = 0; b < 32; b += 7) begin
      doWrite(12'hFB0, KEY ^ (32'h1 << b), "R3 near key");
      doRead(12'hFB4, "R3 stays locked");
    end
    doWrite(12'hFB0, KEY, "R3 unlock");
    doRead(12'hFB4, "R3 unlocked status");

    // Unlocked ownership with upper junk bits
    doWrite(12'hFA0, 32'hFFFF_FFF5, "R8 set with junk");
    doRead(12'hFA4, "R8 tag after set");
    doWrite(12'hFA0, 32'h0000_0002, "R8 set more");
    doRead(12'hFA4, "R8 tag accumulate");
    doWrite(12'hFA4, 32'hFFFF_FFF3, "R9 clear");
    doRead(12'hFA4, "R9 tag after clear");
    doRead(12'hFA0, "R7 mask unlocked");
    doWrite(12'h200, 32'h5, "R6 foreign unlocked permit");
    doWrite(12'hFB4, 32'h0, "R10 status write");
    doRead(12'hFB4, "R10 lock unchanged");
    doWrite(12'hFB0, 32'h0, "R3 relock");
    doRead(12'hFB4, "R3 relocked status");
    doWrite(12'hFA4, 32'hF, "R5 clear while locked");
    doRead(12'hFA4, "R5 tag kept");

    // Constrained random mix
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom_range(0, 5);
      logic [11:0] a;
      logic [31:0] d = $urandom;
      case (sel)
        0: a = 12'hFB0;
        1: a = 12'hFB4;
        2: a = 12'hFA0;
        3: a = 12'hFA4;
        default: a = 12'($urandom_range(0, 12'hF9F));
      endcase
      if (a == 12'hFB0 && $urandom_range(0, 1) == 1) d = KEY;
      if ($urandom_range(0, 2) != 0) doWrite(a, d, "R5 R6 R8 R9 random write");
      else doRead(a, "R2 R4 R7 R11 random read");
      doRead(12'hFA4, "R9 random tag");
      doRead(12'hFB4, "R3 R10 random status");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule